// File: doc/BRIEF.md
# Reciprocal Square-Root Seed Estimator

This unit turns a 64-bit IEEE-754 double-precision operand into a quick estimate of one over its square root, bit for bit the same as a fixed reference formula. A datapath uses it to seed a Newton–Raphson refinement. The normal path picks one of 32 segments with a 5-bit index and reads that segment's base and slope constants from a table inside the block. It then interpolates linearly: the base minus the slope times an 11-bit fraction. Finally it places the result in a fresh exponent and mantissa.

Special operands take a fixed route: zeros, infinities, NaNs and negative numbers. The estimator does not refine the value. Subnormal operands pass through the normal path as if their exponent field held an ordinary value.

The operand arrives with a valid strobe. The result and its valid strobe appear from registers on the following clock. Between strobes the result register keeps its last value. The asynchronous active-low reset is released to the logic through a two-stage synchronizer.

Top module: `rsqrt_est`

## Requirements
- R1: An operand whose bits 62:0 are all zero returns an infinity with the operand's sign: {op[63], 11'h7FF, 52'h0}.
- R2: An exponent field of 11'h7FF with a zero mantissa returns 64'h7FF8_0000_0000_0000 if the sign is set, and 64'h0 if the sign is clear.
- R3: An exponent field of 11'h7FF with a nonzero mantissa (a quiet or signalling NaN) is returned unchanged.
- R4: Any other operand with bit 63 set returns 64'h7FF8_0000_0000_0000.
- R5: The segment index is {op[52], op[51:48]}. Index 0 selects base 0x1A7E800 with slope 0x568, and index 16 selects base 0x3FFA000 with slope 0x7A4. All 32 entries are fixed constants.
- R6: The fraction is op[47:37], an 11-bit unsigned value. The interpolant is the signed 32-bit value base − slope × fraction.
- R7: For an exponent field e, the new exponent is 1023 − ((e − 1021) >> 1), computed as 32-bit unsigned arithmetic. Its low 12 bits are written to bits 63:52 of the word. All other bits of the word are zero.
- R8: The interpolant is sign-extended to 64 bits and shifted left by 26. It is then added to that whole 64-bit word modulo 2^64, so a carry may reach the exponent.
- R9: A positive operand with exponent field 0 (a subnormal) follows the R5–R8 path with e = 0 and receives no other treatment.
- R10: The output valid strobe equals the input valid strobe of the previous clock. Reset clears both the valid strobe and the result register.
- R11: While the input valid strobe is low, the result register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Operand strobe |
| i_op | input | 64 | Operand, IEEE-754 double |
| o_valid | output | 1 | Result strobe, one clock after i_valid |
| o_res | output | 64 | Registered estimate |

## Verification
The bench builds the estimator with its default parameters: 5 index bits, an 11-bit fraction, 26-bit bases, 11-bit slopes, a 32-bit interpolant and an alignment shift of 26. With these values every one of the 32 segments can be reached, both at fraction 0 and at fraction 2047. The stimulus also drives exponent fields below 1021, where the unsigned wrap of the exponent formula decides the top bits of the result, and subnormals with field 0, where the same wrap applies. Valid gaps in the stimulus cover the hold behaviour, and mixed special operands cover the priority order among zero, infinity, NaN and negative values.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int unsigned DW     = 64;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned MAN_W  = 52;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned MUL_W  = 11;
  localparam int unsigned OFF_W  = 26;
  localparam int unsigned STEP_W = 11;
  localparam int unsigned ACC_W  = 32;
  localparam int unsigned ALIGN  = 26;

  localparam logic [DW-1:0] QNAN_WORD = 64'h7FF8_0000_0000_0000;

  typedef struct packed {
    logic [OFF_W-1:0]  base;
    logic [STEP_W-1:0] slope;
  } seg_t;

  typedef enum logic [2:0] {
    K_ZERO,
    K_NINF,
    K_PINF,
    K_NAN,
    K_NEG,
    K_NORM
  } kind_t;

  // Segment constants, indexed by {exponent lsb, top four mantissa bits}.
  function automatic seg_t seg_lookup(input logic [IDX_W-1:0] sel);
    seg_t r;
    r = '0;
    case (sel)
      5'd0:  r = '{26'h1A7E800, 11'h568};
      5'd1:  r = '{26'h17CB800, 11'h4F3};
      5'd2:  r = '{26'h1552800, 11'h48D};
      5'd3:  r = '{26'h130C000, 11'h435};
      5'd4:  r = '{26'h10F2000, 11'h3E7};
      5'd5:  r = '{26'h0EFF000, 11'h3A2};
      5'd6:  r = '{26'h0D2E000, 11'h365};
      5'd7:  r = '{26'h0B7C000, 11'h32E};
      5'd8:  r = '{26'h09E5000, 11'h2FC};
      5'd9:  r = '{26'h0867000, 11'h2D0};
      5'd10: r = '{26'h06FF000, 11'h2A8};
      5'd11: r = '{26'h05AB800, 11'h283};
      5'd12: r = '{26'h046A000, 11'h261};
      5'd13: r = '{26'h0339800, 11'h243};
      5'd14: r = '{26'h0218800, 11'h226};
      5'd15: r = '{26'h0105800, 11'h20B};
      5'd16: r = '{26'h3FFA000, 11'h7A4};
      5'd17: r = '{26'h3C29000, 11'h700};
      5'd18: r = '{26'h38AA000, 11'h670};
      5'd19: r = '{26'h3572000, 11'h5F2};
      5'd20: r = '{26'h3279000, 11'h584};
      5'd21: r = '{26'h2FB7000, 11'h524};
      5'd22: r = '{26'h2D26000, 11'h4CC};
      5'd23: r = '{26'h2AC0000, 11'h47E};
      5'd24: r = '{26'h2881000, 11'h43A};
      5'd25: r = '{26'h2665000, 11'h3FA};
      5'd26: r = '{26'h2468000, 11'h3C2};
      5'd27: r = '{26'h2287000, 11'h38E};
      5'd28: r = '{26'h20C1000, 11'h35E};
      5'd29: r = '{26'h1F12000, 11'h332};
      5'd30: r = '{26'h1D79000, 11'h30A};
      default: r = '{26'h1BF4000, 11'h2E6};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
  import rsq_pkg::*;
#(
  parameter int unsigned W_EXP = EXP_W,
  parameter int unsigned W_MAN = MAN_W,
  localparam int unsigned W_OP = 1 + W_EXP + W_MAN
) (
  input  logic [W_OP-1:0] op,
  output kind_t           kind,
  output logic [W_OP-1:0] special
);

  logic             sgn;
  logic [W_EXP-1:0] exf;
  logic [W_MAN-1:0] man;
  logic             mag_zero;
  logic             exp_max;
  logic             man_zero;

  assign sgn      = op[W_OP-1];
  assign exf      = op[W_OP-2 -: W_EXP];
  assign man      = op[W_MAN-1:0];
  assign mag_zero = (op[W_OP-2:0] == '0);
  assign exp_max  = (exf == {W_EXP{1'b1}});
  assign man_zero = (man == '0);

  // Priority: zero, infinities, NaN, negative, ordinary.
  always_comb begin
    kind    = K_NORM;
    special = '0;
    if (mag_zero) begin
      kind    = K_ZERO;
      special = {sgn, {W_EXP{1'b1}}, {W_MAN{1'b0}}};
    end else if (exp_max && man_zero) begin
      kind    = sgn ? K_NINF : K_PINF;
      special = sgn ? W_OP'(QNAN_WORD) : '0;
    end else if (exp_max) begin
      kind    = K_NAN;
      special = op;
    end else if (sgn) begin
      kind    = K_NEG;
      special = W_OP'(QNAN_WORD);
    end
  end

endmodule

// File: rtl/rsq_interp.sv
module rsq_interp
  import rsq_pkg::*;
#(
  parameter int unsigned W_IDX  = IDX_W,
  parameter int unsigned W_MUL  = MUL_W,
  parameter int unsigned W_ACC  = ACC_W,
  localparam int unsigned W_PROD = STEP_W + W_MUL
) (
  input  logic [W_IDX-1:0] idx,
  input  logic [W_MUL-1:0] frac,
  output logic [W_ACC-1:0] acc
);

  seg_t              seg;
  logic [W_PROD-1:0] prod;

  always_comb begin
    seg  = seg_lookup(IDX_W'(idx));
    prod = W_PROD'(seg.slope) * W_PROD'(frac);
    acc  = W_ACC'(seg.base) - W_ACC'(prod);
  end

endmodule

// File: rtl/rsq_assemble.sv
module rsq_assemble
  import rsq_pkg::*;
#(
  parameter int unsigned W_EXP = EXP_W,
  parameter int unsigned W_MAN = MAN_W,
  parameter int unsigned W_ACC = ACC_W,
  parameter int unsigned SHIFT = ALIGN,
  localparam int unsigned W_OP = 1 + W_EXP + W_MAN,
  localparam int unsigned W_HI = W_EXP + 1,
  localparam int unsigned W_T  = W_EXP + 2
) (
  input  logic [W_OP-1:0]  op,
  input  logic [W_ACC-1:0] acc,
  output logic [W_OP-1:0]  res
);

  localparam logic [W_T-1:0]  OFS  = W_T'(1021);
  localparam logic [W_HI-1:0] BIAS = W_HI'(1023);

  logic [W_T-1:0]  diff;
  logic [W_HI-1:0] enew;
  logic [W_OP-1:0] frame;
  logic [W_OP-1:0] addend;

  always_comb begin
    // Only the low W_HI bits of the wrapped exponent reach the word.
    diff   = W_T'(op[W_OP-2 -: W_EXP]) - OFS;
    enew   = BIAS - diff[W_T-1:1];
    frame  = {op[W_OP-1] | enew[W_HI-1], enew[W_EXP-1:0], {W_MAN{1'b0}}};
    addend = {{(W_OP-W_ACC){acc[W_ACC-1]}}, acc} << SHIFT;
    res    = frame + addend;
  end

endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsq_pkg::*;
#(
  parameter int unsigned W_EXP = EXP_W,
  parameter int unsigned W_MAN = MAN_W,
  parameter int unsigned W_IDX = IDX_W,
  parameter int unsigned W_MUL = MUL_W,
  parameter int unsigned W_ACC = ACC_W,
  parameter int unsigned SHIFT = ALIGN,
  localparam int unsigned W_OP = 1 + W_EXP + W_MAN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_valid,
  input  logic [W_OP-1:0] i_op,
  output logic            o_valid,
  output logic [W_OP-1:0] o_res
);

  logic            rs_a;
  logic            rs_b;
  logic            rst_sync_n;
  kind_t           kind;
  logic [W_OP-1:0] special;
  logic [W_ACC-1:0] acc;
  logic [W_OP-1:0] ordinary;
  logic [W_OP-1:0] res_d;
  logic            vld_d;
  logic            res_en;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end
  assign rst_sync_n = rs_b;

  rsq_classify #(.W_EXP(W_EXP), .W_MAN(W_MAN)) u_cls (
    .op      (i_op),
    .kind    (kind),
    .special (special)
  );

  rsq_interp #(.W_IDX(W_IDX), .W_MUL(W_MUL), .W_ACC(W_ACC)) u_itp (
    .idx  (i_op[W_MAN -: W_IDX]),
    .frac (i_op[W_MAN-W_IDX -: W_MUL]),
    .acc  (acc)
  );

  rsq_assemble #(.W_EXP(W_EXP), .W_MAN(W_MAN), .W_ACC(W_ACC), .SHIFT(SHIFT)) u_asm (
    .op  (i_op),
    .acc (acc),
    .res (ordinary)
  );

  always_comb begin
    res_en = i_valid;
    vld_d  = i_valid;
    res_d  = (kind == K_NORM) ? ordinary : special;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      o_valid <= 1'b0;
      o_res   <= '0;
    end else begin
      o_valid <= vld_d;
      if (res_en) o_res <= res_d;
    end
  end

endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        i_valid,
  input logic [63:0] i_op,
  input logic        o_valid,
  input logic [63:0] o_res
);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |=> o_valid);  // R10
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |=> !o_valid);  // R10
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |=> $stable(o_res));  // R11
  AST_ZERO_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op[62:0] == 63'd0) |=> (o_res == {$past(i_op[63]), 11'h7FF, 52'd0}));  // R1
  AST_NINF_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == 64'hFFF0_0000_0000_0000) |=> (o_res == 64'h7FF8_0000_0000_0000));  // R2
  AST_PINF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == 64'h7FF0_0000_0000_0000) |=> (o_res == 64'd0));  // R2
  AST_NAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op[62:52] == 11'h7FF && i_op[51:0] != 52'd0) |=> (o_res == $past(i_op)));  // R3
  AST_NEG_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op[63] && i_op[62:52] != 11'h7FF && i_op[62:0] != 63'd0)
      |=> (o_res == 64'h7FF8_0000_0000_0000));  // R4

endmodule

bind rsqrt_est rsqrt_est_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .i_valid (i_valid),
  .i_op    (i_op),
  .o_valid (o_valid),
  .o_res   (o_res)
);

// File: tb/rsqrt_est_bench.sv
`timescale 1ns/1ps
module rsqrt_est_bench;

  logic        clk;
  logic        rst_n;
  logic        i_valid;
  logic [63:0] i_op;
  logic        o_valid;
  logic [63:0] o_res;

  int          n_chk;
  int          n_err;
  bit          checking;
  bit          done;
  logic        exp_vld;
  logic [63:0] exp_res;
  string       exp_tag;
  string       cur_tag;

  int unsigned t_base [32] = '{
    32'h1A7E800, 32'h17CB800, 32'h1552800, 32'h130C000, 32'h10F2000, 32'h0EFF000,
    32'h0D2E000, 32'h0B7C000, 32'h09E5000, 32'h0867000, 32'h06FF000, 32'h05AB800,
    32'h046A000, 32'h0339800, 32'h0218800, 32'h0105800, 32'h3FFA000, 32'h3C29000,
    32'h38AA000, 32'h3572000, 32'h3279000, 32'h2FB7000, 32'h2D26000, 32'h2AC0000,
    32'h2881000, 32'h2665000, 32'h2468000, 32'h2287000, 32'h20C1000, 32'h1F12000,
    32'h1D79000, 32'h1BF4000};
  int unsigned t_slope [32] = '{
    32'h568, 32'h4F3, 32'h48D, 32'h435, 32'h3E7, 32'h3A2, 32'h365, 32'h32E,
    32'h2FC, 32'h2D0, 32'h2A8, 32'h283, 32'h261, 32'h243, 32'h226, 32'h20B,
    32'h7A4, 32'h700, 32'h670, 32'h5F2, 32'h584, 32'h524, 32'h4CC, 32'h47E,
    32'h43A, 32'h3FA, 32'h3C2, 32'h38E, 32'h35E, 32'h332, 32'h30A, 32'h2E6};

  rsqrt_est u_rsqrt_est (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_valid (i_valid),
    .i_op    (i_op),
    .o_valid (o_valid),
    .o_res   (o_res)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] model(input logic [63:0] x);
    int unsigned e, idx, mul, ne;
    int          acc;
    logic [63:0] r, sx;
    if (x[62:0] == 63'd0) return {x[63], 11'h7FF, 52'd0};
    e = int'(x[62:52]);
    if (e == 2047) begin
      if (x[51:0] == 52'd0) return x[63] ? 64'h7FF8_0000_0000_0000 : 64'd0;
      return x;
    end
    if (x[63]) return 64'h7FF8_0000_0000_0000;
    idx = int'(x[52:48]);
    mul = int'(x[47:37]);
    acc = int'(t_base[idx]) - int'(t_slope[idx] * mul);
    ne  = 32'd1023 - ((e - 32'd1021) >> 1);
    r   = {ne[11:0], 52'd0};
    sx  = {{32{acc[31]}}, acc};
    r   = r + (sx << 26);
    return r;
  endfunction

  function automatic string tag_of(input logic [63:0] x);
    if (x[62:0] == 63'd0) return "R1";
    if (x[62:52] == 11'h7FF) return (x[51:0] == 52'd0) ? "R2" : "R3";
    if (x[63]) return "R4";
    if (x[62:52] == 11'd0) return "R9";
    if (x[62:52] < 11'd1021) return "R7";
    return cur_tag;
  endfunction

  // Reference model state, advanced on each rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_vld <= 1'b0;
      exp_res <= 64'd0;
      exp_tag <= "R10";
    end else begin
      exp_vld <= i_valid;
      if (i_valid) begin
        exp_res <= model(i_op);
        exp_tag <= tag_of(i_op);
      end else begin
        exp_tag <= "R11";
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      n_chk++;
      if (o_valid !== exp_vld) begin
        n_err++;
        $display("FAIL R10 o_valid actual=%0b expected=%0b", o_valid, exp_vld);
      end else if (o_res !== exp_res) begin
        n_err++;
        $display("FAIL %s o_res actual=%016h expected=%016h", exp_tag, o_res, exp_res);
      end
    end
  end

  task automatic send(input logic [63:0] x);
    @(negedge clk);
    i_valid = 1'b1;
    i_op    = x;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      i_valid = 1'b0;
      i_op    = {$urandom, $urandom};
    end
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk    = 0;
    n_err    = 0;
    checking = 1'b0;
    cur_tag  = "R5";
    rst_n    = 1'b0;
    i_valid  = 1'b0;
    i_op     = 64'd0;
    repeat (3) @(negedge clk);
    // R10: reset state
    n_chk++;
    if (o_valid !== 1'b0 || o_res !== 64'd0) begin
      n_err++;
      $display("FAIL R10 reset actual=%0b/%016h expected=0/0", o_valid, o_res);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checking = 1'b1;

    send(64'h0000_0000_0000_0000);          // R1
    send(64'h8000_0000_0000_0000);          // R1
    send(64'hFFF0_0000_0000_0000);          // R2
    send(64'h7FF0_0000_0000_0000);          // R2
    send(64'h7FF8_0000_0000_0000);          // R3
    send(64'hFFF0_0000_0000_0001);          // R3
    send(64'h7FF4_1234_5678_9ABC);          // R3
    send(64'hBFF0_0000_0000_0000);          // R4
    send(64'h8000_0000_0000_0001);          // R4
    idle(3);                                // R11
    cur_tag = "R5";
    for (int i = 0; i < 32; i++)
      send({1'b0, 10'h1FF, i[4], i[3:0], 48'd0});
    cur_tag = "R6";
    for (int i = 0; i < 32; i++) begin
      send({1'b0, 10'h1FF, i[4], i[3:0], 11'h7FF, 37'd0});
      send({1'b0, 10'h1FF, i[4], i[3:0], 11'($urandom), 37'($urandom)});
    end
    send(64'h0000_0000_0000_0001);          // R9
    send(64'h000F_FFFF_FFFF_FFFF);          // R9
    send(64'h0001_0000_0000_0000);          // R9
    cur_tag = "R7";
    send(64'h0010_0000_0000_0000);          // R7 e=1
    send(64'h1F40_0000_0000_0000);          // R7 e=500
    send(64'h3FC0_0000_0000_0000);          // R7 e=1020
    send(64'h3FD0_0000_0000_0000);          // R7 e=1021
    send(64'h3FE8_0000_0000_0000);          // R7 e=1022
    send(64'h7FE0_0000_0000_0000);          // R7 e=2046
    idle(2);                                // R11
    cur_tag = "R8";
    for (int i = 0; i < 300; i++) begin
      send({1'b0, 63'({$urandom, $urandom})});
      if ($urandom_range(0, 3) == 0) idle(1 + $urandom_range(0, 2));
    end
    idle(3);
    done = 1'b1;
    checking = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule